// File: doc/BRIEF.md
# Write-Through Subblock-Valid Cache

A small direct-mapped data cache with a write-through policy. Each line holds several one-word subblocks under one address tag. Every subblock carries its own valid bit. Reads are looked up in the same cycle. A read that hits returns the word with no stall. A read that misses stalls the CPU while the whole line is fetched from memory one word at a time. After the fetch, every subblock of that line is valid.

Single-word stores never do a hit check before writing. A store always writes the data word and the tag of its line. It then adjusts the valid bits:
- If the tag already matched, the written subblock becomes (or stays) valid.
- If the tag did not match, only the written subblock stays valid.

Memory always holds a current copy of every word, so dropping the other subblocks loses nothing. Each store is also sent to memory through a one-entry store register. A store stalls only while that register is still occupied and memory is not taking it.

Top module: `wt_subblock_cache`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and empties the store register. After reset, the first read of any line is a miss, and neither memory port is active.
- R2: A read whose line tag equals the address tag and whose addressed subblock is valid raises the hit flag in the same cycle. In that cycle it returns the word on the read data output with no stall.
- R3: Any other read stalls the CPU and requests a line fill. The fill line address is the word address without its low offset bits. Memory returns the words in offset order 0, 1, 2, 3, one per cycle in which the fill-valid input is high. After the last word, all subblocks of the line are valid under the new tag.
- R4: Every store that is not stalled appears on the memory write port in the next cycle, with its word address and data.
- R5: A store whose tag matches a line with the target subblock invalid makes that subblock valid with the new data. The other valid bits of the line are left unchanged.
- R6: A store whose tag does not match replaces the line tag and writes the word. It leaves only the written subblock valid, so reads of the other offsets then miss.
- R7: A store stalls only while the store register holds an entry that memory is not accepting in that cycle. A store issued when the register is empty or draining is absorbed with no stall.
- R8: A read miss does not request a fill until the store register is empty. A fill therefore always sees every earlier store in memory.
- R9: A store to a matching line whose subblock is already valid updates the word and keeps every valid bit of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU request present; held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: tag, index, offset from high to low |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when cpu_hit is high |
| cpu_hit | output | 1 | Load hit in this cycle |
| cpu_stall | output | 1 | CPU must hold its request |
| mw_valid | output | 1 | Store register holds a word for memory |
| mw_ready | input | 1 | Memory accepts the word this cycle |
| mw_addr | output | ADDR_W | Word address of the outgoing store |
| mw_data | output | DATA_W | Data of the outgoing store |
| mf_req | output | 1 | Line fill in progress |
| mf_addr | output | ADDR_W-OFF_W | Line address of the fill |
| mf_valid | input | 1 | A fill word is present |
| mf_data | input | DATA_W | Fill word, in offset order |

## Verification
The hardest situation to reach is a read miss on a line whose newest store is still waiting in the store register. Both the ordering (R8) and the data returned depend on the fill waiting for that store. The bench holds memory's write-ready low, stores into a line under a new tag, and then reads another offset of that line. It confirms that no fill is requested while the store is held. After release, it confirms that the stored word reads back. Exhaustive read sweeps over all 256 addresses, and store sequences at every offset of every line, cover the remaining valid-bit cases against an arithmetic model of tags and valid bits.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;
endpackage

// File: rtl/wtc_line_store.sv
// Tag, subblock-valid and data arrays; combinational lookup.
module wtc_line_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [OFF_W-1:0]  lk_off,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_index,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic [OFF_W-1:0]  st_off,
    input  logic [DATA_W-1:0] st_data,
    input  logic              fl_en,
    input  logic              fl_last,
    input  logic [IDX_W-1:0]  fl_index,
    input  logic [TAG_W-1:0]  fl_tag,
    input  logic [OFF_W-1:0]  fl_off,
    input  logic [DATA_W-1:0] fl_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0]             tag;
        logic [LINES-1:0][WORDS-1:0]             vld;
        logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (st_en) begin
            s_d.dat[st_index][st_off] = st_data;
            if (s_q.tag[st_index] == st_tag) begin
                s_d.vld[st_index][st_off] = 1'b1;
            end else begin
                s_d.tag[st_index] = st_tag;
                s_d.vld[st_index] = WORDS'(1) << st_off;
            end
        end
        if (fl_en) begin
            s_d.dat[fl_index][fl_off] = fl_data;
            if (fl_last) begin
                s_d.tag[fl_index] = fl_tag;
                s_d.vld[fl_index] = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign lk_hit  = (s_q.tag[lk_index] == lk_tag) && s_q.vld[lk_index][lk_off];
    assign lk_data = s_q.dat[lk_index][lk_off];
endmodule

// File: rtl/wtc_store_buffer.sv
// One-entry register carrying write-through traffic to memory.
module wtc_store_buffer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              blocked
);
    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (b_q.v && out_ready) b_d.v = 1'b0;
        if (ld_en) begin
            b_d.v    = 1'b1;
            b_d.addr = ld_addr;
            b_d.data = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    assign out_valid = b_q.v;
    assign out_addr  = b_q.addr;
    assign out_data  = b_q.data;
    assign blocked   = b_q.v && !out_ready;
endmodule

// File: rtl/wtc_fill_ctrl.sv
// Line-fill sequencer: waits for an empty store register, then counts beats.
module wtc_fill_ctrl #(
    parameter int IDX_W = 2,
    parameter int OFF_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_miss,
    input  logic                   buf_empty,
    input  logic [IDX_W-1:0]       miss_index,
    input  logic [TAG_W-1:0]       miss_tag,
    output logic                   busy,
    output logic [TAG_W+IDX_W-1:0] line_addr,
    input  logic                   beat_valid,
    output logic                   fl_en,
    output logic                   fl_last,
    output logic [IDX_W-1:0]       fl_index,
    output logic [TAG_W-1:0]       fl_tag,
    output logic [OFF_W-1:0]       fl_off
);
    import wtc_pkg::*;

    localparam int WORDS = 1 << OFF_W;

    typedef struct packed {
        fill_state_e      st;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] index;
        logic [OFF_W-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            FILL_IDLE: begin
                if (rd_miss && buf_empty) begin
                    c_d.st    = FILL_RUN;
                    c_d.tag   = miss_tag;
                    c_d.index = miss_index;
                    c_d.cnt   = '0;
                end
            end
            default: begin
                if (beat_valid) begin
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (c_q.cnt == OFF_W'(WORDS - 1)) c_d.st = FILL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{st: FILL_IDLE, default: '0};
        else     c_q <= c_d;
    end

    assign busy      = (c_q.st == FILL_RUN);
    assign line_addr = {c_q.tag, c_q.index};
    assign fl_en     = busy && beat_valid;
    assign fl_last   = fl_en && (c_q.cnt == OFF_W'(WORDS - 1));
    assign fl_index  = c_q.index;
    assign fl_tag    = c_q.tag;
    assign fl_off    = c_q.cnt;
endmodule

// File: rtl/wt_subblock_cache.sv
// Direct-mapped write-through cache with per-word valid bits.
module wt_subblock_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    cpu_hit,
    output logic                    cpu_stall,
    output logic                    mw_valid,
    input  logic                    mw_ready,
    output logic [ADDR_W-1:0]       mw_addr,
    output logic [DATA_W-1:0]       mw_data,
    output logic                    mf_req,
    output logic [ADDR_W-OFF_W-1:0] mf_addr,
    input  logic                    mf_valid,
    input  logic [DATA_W-1:0]       mf_data
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic             rd_req, wr_req, lk_hit, busy, blocked, st_en, rd_miss;
    logic             fl_en, fl_last;
    logic [IDX_W-1:0] fl_index;
    logic [TAG_W-1:0] fl_tag;
    logic [OFF_W-1:0] fl_off;

    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_off  = cpu_addr[OFF_W-1:0];
    assign rd_req = cpu_req && !cpu_we;
    assign wr_req = cpu_req && cpu_we;

    assign rd_miss   = rd_req && !lk_hit && !busy;
    assign st_en     = wr_req && !blocked && !busy;
    assign cpu_hit   = rd_req && lk_hit && !busy;
    assign cpu_stall = busy || (rd_req && !lk_hit) || (wr_req && blocked);
    assign mf_req    = busy;

    wtc_line_store #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .lk_index (a_idx),
        .lk_tag   (a_tag),
        .lk_off   (a_off),
        .lk_hit   (lk_hit),
        .lk_data  (cpu_rdata),
        .st_en    (st_en),
        .st_index (a_idx),
        .st_tag   (a_tag),
        .st_off   (a_off),
        .st_data  (cpu_wdata),
        .fl_en    (fl_en),
        .fl_last  (fl_last),
        .fl_index (fl_index),
        .fl_tag   (fl_tag),
        .fl_off   (fl_off),
        .fl_data  (mf_data)
    );

    wtc_store_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sbuf (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (st_en),
        .ld_addr   (cpu_addr),
        .ld_data   (cpu_wdata),
        .out_valid (mw_valid),
        .out_ready (mw_ready),
        .out_addr  (mw_addr),
        .out_data  (mw_data),
        .blocked   (blocked)
    );

    wtc_fill_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .rd_miss    (rd_miss),
        .buf_empty  (!mw_valid),
        .miss_index (a_idx),
        .miss_tag   (a_tag),
        .busy       (busy),
        .line_addr  (mf_addr),
        .beat_valid (mf_valid),
        .fl_en      (fl_en),
        .fl_last    (fl_last),
        .fl_index   (fl_index),
        .fl_tag     (fl_tag),
        .fl_off     (fl_off)
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_hit,
    input logic              cpu_stall,
    input logic              mw_valid,
    input logic              mw_ready,
    input logic [ADDR_W-1:0] mw_addr,
    input logic [DATA_W-1:0] mw_data,
    input logic              mf_req
);
    // R1: ports quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mw_valid && !mf_req));

    // R2: a hit never stalls
    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> !cpu_stall);

    // R3: CPU is held for the whole fill
    a_r3_fill_stalls: assert property (@(posedge clk) disable iff (rst)
        mf_req |-> cpu_stall);

    // R4: an accepted store reaches the memory port next cycle
    a_r4_store_forwarded: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |=>
        (mw_valid && mw_addr == $past(cpu_addr) && mw_data == $past(cpu_wdata)));

    // R7: held store stays stable; store stalls only behind a refused entry
    a_r7_buffer_holds: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    a_r7_stall_cause: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_stall && !mf_req) |-> (mw_valid && !mw_ready));

    // R8: a fill starts only after the store register emptied
    a_r8_fill_after_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(mf_req) |-> !$past(mw_valid));
endmodule

bind wt_subblock_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wt_subblock_cache_tb.sv
module wt_subblock_cache_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 2;
    localparam int OFF_W  = 2;
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << OFF_W;
    localparam int NADDR  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic cpu_hit, cpu_stall;
    logic mw_valid;
    logic mw_ready = 1'b1;
    logic [ADDR_W-1:0] mw_addr;
    logic [DATA_W-1:0] mw_data;
    logic mf_req;
    logic [ADDR_W-OFF_W-1:0] mf_addr;
    logic mf_valid = 1'b0;
    logic [DATA_W-1:0] mf_data = '0;

    always #(CLK_P/2) clk = ~clk;

    wt_subblock_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .mf_req(mf_req), .mf_addr(mf_addr), .mf_valid(mf_valid), .mf_data(mf_data)
    );

    logic [DATA_W-1:0] mem    [NADDR];
    logic [DATA_W-1:0] shadow [NADDR];
    logic [3:0]        m_tag  [LINES];
    logic [WORDS-1:0]  m_val  [LINES];
    int n_chk = 0, n_fail = 0, fbeat = 0, seq = 0;
    logic gap = 1'b0;

    function automatic logic [DATA_W-1:0] init_word(input int a);
        return {a[7:0], ~a[7:0], a[7:0] ^ 8'h5A, 8'h3C};
    endfunction

    task automatic check(input logic ok, input string rq, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // memory model: write port and line fill
    initial forever begin
        @(posedge clk);
        if (mw_valid && mw_ready) mem[mw_addr] = mw_data;
        if (mf_valid) fbeat = fbeat + 1;
    end

    initial forever begin
        @(negedge clk);
        if (mf_req && fbeat < WORDS) begin
            gap      = !gap;
            mf_valid = gap;
            mf_data  = mem[{mf_addr, fbeat[OFF_W-1:0]}];
        end else begin
            mf_valid = 1'b0;
            if (!mf_req) fbeat = 0;
        end
    end

    function automatic logic model_hit(input logic [ADDR_W-1:0] a);
        return (m_tag[a[3:2]] == a[7:4]) && m_val[a[3:2]][a[1:0]];
    endfunction

    task automatic model_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        if (m_tag[a[3:2]] == a[7:4]) m_val[a[3:2]][a[1:0]] = 1'b1;
        else begin
            m_tag[a[3:2]] = a[7:4];
            m_val[a[3:2]] = WORDS'(1) << a[1:0];
        end
        shadow[a] = d;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string rq);
        logic eh;
        int n;
        eh = model_hit(a);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        check(cpu_hit == eh, rq, 32'(cpu_hit), 32'(eh));
        if (!eh) begin
            check(cpu_stall == 1'b1, "R3", 32'(cpu_stall), 32'd1);
            n = 0;
            while (cpu_stall && n < 200) begin
                @(negedge clk); #1; n++;
            end
            m_tag[a[3:2]] = a[7:4];
            m_val[a[3:2]] = '1;
        end
        check(cpu_hit && !cpu_stall, rq, {cpu_hit, cpu_stall}, 2'b10);
        check(cpu_rdata == shadow[a], rq, cpu_rdata, shadow[a]);
        cpu_req = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic es;
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        es = mw_valid && !mw_ready;
        check(cpu_stall == es, "R7", 32'(cpu_stall), 32'(es));
        n = 0;
        while (cpu_stall && n < 200) begin
            @(negedge clk); #1; n++;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        check(mw_valid && mw_addr == a && mw_data == d, "R4", mw_data, d);
        model_store(a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a, a2;
        logic [3:0] tg;
        int n;
        for (int i = 0; i < NADDR; i++) begin
            mem[i] = init_word(i);
            shadow[i] = init_word(i);
        end
        for (int l = 0; l < LINES; l++) begin
            m_tag[l] = '0;
            m_val[l] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!mw_valid && !mf_req, "R1", {mw_valid, mf_req}, 2'b00);

        // R1: each line misses after reset
        for (int l = 0; l < LINES; l++) do_read(ADDR_W'(l * WORDS + 1), "R1");

        // R2/R3: sweep all addresses
        for (int i = 0; i < NADDR; i++)
            do_read(ADDR_W'(i), model_hit(ADDR_W'(i)) ? "R2" : "R3");

        // R6, R5, R9 at every offset of every line
        for (int l = 0; l < LINES; l++) begin
            for (int k = 0; k < WORDS; k++) begin
                tg = m_tag[l] + 4'(k + 1);
                a = {tg, 2'(l), 2'(k)};
                seq++;
                do_write(a, 32'hD000_0000 + 32'(seq));                 // R6
                a2 = {tg, 2'(l), 2'(k + 2)};
                seq++;
                do_write(a2, 32'hE000_0000 + 32'(seq));                // R5
                check(!model_hit({tg, 2'(l), 2'(k + 1)}), "R6", 32'd1, 32'd0);
                do_read(a, "R6");
                do_read(a2, "R5");
                do_read({tg, 2'(l), 2'(k + 1)}, "R6");
                do_read({tg, 2'(l), 2'(k + 3)}, "R3");
                seq++;
                do_write(a, 32'hF000_0000 + 32'(seq));                 // R9
                for (int j = 0; j < WORDS; j++) do_read({tg, 2'(l), 2'(j)}, "R9");
            end
        end

        // R7: store stalls behind a refused entry
        mw_ready = 1'b0;
        do_write(8'h21, 32'h1111_0001);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h22; cpu_wdata = 32'h1111_0002;
        #1;
        check(cpu_stall == 1'b1, "R7", 32'(cpu_stall), 32'd1);
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); #1;
            check(cpu_stall && mw_addr == 8'h21, "R7", 32'(mw_addr), 32'h21);
        end
        @(negedge clk);
        mw_ready = 1'b1;
        #1;
        check(cpu_stall == 1'b0, "R7", 32'(cpu_stall), 32'd0);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        check(mw_valid && mw_addr == 8'h22 && mw_data == 32'h1111_0002, "R7", mw_data, 32'h1111_0002);
        model_store(8'h22, 32'h1111_0002);
        do_read(8'h21, "R7");
        do_read(8'h22, "R7");

        // R8: read miss waits for the held store, then sees it
        mw_ready = 1'b0;
        do_write(8'hB5, 32'h8888_0005);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'hB6;
        #1;
        check(cpu_stall && !cpu_hit, "R8", {cpu_stall, cpu_hit}, 2'b10);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            check(!mf_req && cpu_stall, "R8", {mf_req, cpu_stall}, 2'b01);
        end
        mw_ready = 1'b1;
        n = 0;
        while (cpu_stall && n < 200) begin
            @(negedge clk); #1; n++;
        end
        check(cpu_hit && cpu_rdata == shadow[8'hB6], "R8", cpu_rdata, shadow[8'hB6]);
        cpu_req = 1'b0;
        m_tag[1] = 4'hB;
        m_val[1] = '1;
        do_read(8'hB5, "R8");
        check(mem[8'hB5] == 32'h8888_0005, "R8", mem[8'hB5], 32'h8888_0005);

        // R1: reset again clears valid bits
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < LINES; l++) m_val[l] = '0;
        #1;
        check(!mw_valid && !mf_req, "R1", {mw_valid, mf_req}, 2'b00);
        do_read(8'hB5, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule